// File: doc/BRIEF.md
# Addressable Serial Register Port for a Dual-Channel Converter

This block is the serial slave that lets a host controller reach the registers of a two-channel sampling converter. The host drives a serial clock, a select line and a data-in line; the block returns read data on a data-out line with a separate pad enable. Serial clock polarity may idle low or high (SPI modes 0 and 3). Bit timing is the same in both: incoming bits are taken on the rising clock edge and outgoing bits change on the falling edge. The block oversamples the serial lines with the fast system clock.

Each transfer opens with a control byte. It carries a two-bit device address, so that several converters can share one select line, a five-bit register address and a read/write flag. Bytes then stream in either direction. The register address advances after every byte and loops inside its register group. A host can therefore read the six sample bytes again and again in one transfer. The two 24-bit sample words are captured together, so the bytes of one pass through the sample group always come from one sampling instant.

Top module: `conv_spi_regif`

## Requirements
- R1: The control byte is bits [7:6] device address, bits [5:1] register address, bit [0] read flag (1 = read, 0 = write). The block answers only when bits [7:6] equal the parameter DEV_ADDR, which defaults to 2'b00.
- R2: After a control byte whose device address does not match, the block writes nothing and keeps spi_miso_oe low until the select line rises.
- R3: Input bits are taken on rising serial clock edges and output bits change on falling edges, MSB first. This holds with the clock idling low and with the clock idling high.
- R4: spi_miso_oe is low while spi_csn is high and throughout the control byte. It is high only while a matched read streams data.
- R5: The register addresses are: 0x00-0x02 channel 0 sample (upper, middle, lower byte), 0x03-0x05 channel 1 sample (same order), 0x06 modulator bits, 0x07 phase, 0x08 gain, 0x09 status, 0x0A control 1, 0x0B control 2. The five configuration bytes reset to 0x00 and drive the cfg_* outputs.
- R6: During a read the address advances after each byte. From 0x05 it returns to 0x00, and from 0x0B it returns to 0x06.
- R7: Writes stream with the same address stepping. Write data sent to 0x00-0x06 is discarded and leaves every configuration byte unchanged.
- R8: Status bits [1:0] and control 1 bits [7:6] are unimplemented. They are never stored and read back as 0.
- R9: Addresses 0x0C-0x1F read as 0x00 and ignore writes, and the address does not step past them.
- R10: Raising spi_csn at any bit ends the transfer. A partly received byte is discarded, and the next transfer starts fresh with a control byte.
- R11: Both sample words are captured together when a read control byte is decoded and whenever a read returns to address 0x00. The byte sent for 0x00 at that moment already carries the fresh capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_csn | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Pad enable for spi_miso (low = high impedance) |
| ch0_sample | input | 24 | Live channel 0 sample word |
| ch1_sample | input | 24 | Live channel 1 sample word |
| mod_bits | input | 8 | Live modulator output byte |
| cfg_phase | output | 8 | Phase configuration byte |
| cfg_gain | output | 8 | Gain configuration byte |
| cfg_status | output | 8 | Status/communication configuration byte |
| cfg_ctrl1 | output | 8 | Control byte 1 |
| cfg_ctrl2 | output | 8 | Control byte 2 |

## Verification
Two things can happen in the same system-clock cycle: the capture of both sample words and the loading of the outgoing byte for address 0x00. The load must use the fresh capture, not the held one. To provoke this, the bench changes both live sample words in the middle of a looping read, just after the first byte has left. It then expects the rest of that pass to carry the old words and the first bytes of the next pass to carry the new ones. The scoreboard queue holds each expected byte in transfer order, so an error on either side of the wrap shows up as a mismatch on a specific byte.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;

    localparam int BYTE_W       = 8;
    localparam int DATA_W       = 24;
    localparam int NUM_CH       = 2;
    localparam int ADDR_W       = 5;
    localparam int DEVA_W       = 2;
    localparam int SYNC_STAGES  = 2;
    localparam int BYTES_PER_CH = DATA_W / BYTE_W;
    localparam int DATA_BYTES   = NUM_CH * BYTES_PER_CH;
    localparam int CNT_W        = $clog2(BYTE_W);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BYTE_W-1:0] byte_t;

    localparam addr_t A_DATA_LAST = addr_t'(DATA_BYTES - 1);
    localparam addr_t A_MODOUT    = addr_t'(DATA_BYTES);
    localparam addr_t A_PHASE     = addr_t'(DATA_BYTES + 1);
    localparam addr_t A_GAIN      = addr_t'(DATA_BYTES + 2);
    localparam addr_t A_STAT      = addr_t'(DATA_BYTES + 3);
    localparam addr_t A_CTL1      = addr_t'(DATA_BYTES + 4);
    localparam addr_t A_CTL2      = addr_t'(DATA_BYTES + 5);

    localparam byte_t MASK_STAT = 8'hFC;
    localparam byte_t MASK_CTL1 = 8'h3F;

    typedef enum logic [1:0] {
        PH_CMD,
        PH_DATA,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic [DEVA_W-1:0] dev;
        addr_t             reg_addr;
        logic              rd;
    } ctrl_byte_t;

    typedef struct packed {
        byte_t phase;
        byte_t gain;
        byte_t stat;
        byte_t ctl1;
        byte_t ctl2;
    } cfg_t;

    // Address stepping: loop inside the sample group and the control group,
    // park on addresses outside the map.
    function automatic addr_t step_addr(addr_t a);
        if (a == A_DATA_LAST)
            return '0;
        else if (a == A_CTL2)
            return A_MODOUT;
        else if (a > A_CTL2)
            return a;
        else
            return a + addr_t'(1);
    endfunction

endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync
    import spi_regif_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic spi_sck,
    input  logic spi_csn,
    input  logic spi_mosi,
    output logic cs_act,
    output logic sck_rise,
    output logic sck_fall,
    output logic mosi_s
);

    logic [STAGES-1:0] sck_q;
    logic [STAGES-1:0] csn_q;
    logic [STAGES-1:0] mosi_q;
    logic              sck_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q  <= '0;
            csn_q  <= '1;
            mosi_q <= '0;
            sck_d  <= 1'b0;
        end else begin
            sck_q  <= {sck_q[STAGES-2:0], spi_sck};
            csn_q  <= {csn_q[STAGES-2:0], spi_csn};
            mosi_q <= {mosi_q[STAGES-2:0], spi_mosi};
            sck_d  <= sck_q[STAGES-1];
        end
    end

    assign cs_act   = ~csn_q[STAGES-1];
    assign sck_rise = cs_act &  sck_q[STAGES-1] & ~sck_d;
    assign sck_fall = cs_act & ~sck_q[STAGES-1] &  sck_d;
    assign mosi_s   = mosi_q[STAGES-1];

endmodule

// File: rtl/spi_frame_ctl.sv
module spi_frame_ctl
    import spi_regif_pkg::*;
#(
    parameter logic [DEVA_W-1:0] DEV_ADDR = '0
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   cs_act,
    input  logic   sck_rise,
    input  logic   sck_fall,
    input  logic   mosi_s,
    input  byte_t  rd_byte,
    output addr_t  rd_addr,
    output logic   ld_en,
    output logic   snap_en,
    output logic   wr_en,
    output addr_t  wr_addr,
    output byte_t  wr_data,
    output addr_t  cur_addr,
    output phase_e phase,
    output logic   miso,
    output logic   miso_oe
);

    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-2:0] rx_sh;
    logic              rd_mode;
    byte_t             tx_sh;
    logic              out_bit;
    byte_t             rx_byte;
    ctrl_byte_t        cmd;
    logic              byte_end;
    logic              match;

    assign rx_byte  = {rx_sh, mosi_s};
    assign cmd      = rx_byte;
    assign match    = (cmd.dev == DEV_ADDR);
    assign byte_end = sck_rise && (bit_cnt == CNT_W'(BYTE_W - 1));

    assign rd_addr = (phase == PH_CMD) ? cmd.reg_addr : cur_addr;
    assign ld_en   = byte_end && (((phase == PH_CMD) && match && cmd.rd) ||
                                  ((phase == PH_DATA) && rd_mode));
    assign snap_en = ld_en && ((phase == PH_CMD) || (cur_addr == '0));
    assign wr_en   = byte_end && (phase == PH_DATA) && !rd_mode;
    assign wr_addr = cur_addr;
    assign wr_data = rx_byte;

    always_ff @(posedge clk) begin
        if (rst || !cs_act) begin
            bit_cnt  <= '0;
            rx_sh    <= '0;
            phase    <= PH_CMD;
            rd_mode  <= 1'b0;
            cur_addr <= '0;
            tx_sh    <= '0;
            out_bit  <= 1'b0;
        end else begin
            if (sck_rise) begin
                rx_sh   <= rx_byte[BYTE_W-2:0];
                bit_cnt <= bit_cnt + CNT_W'(1);
            end
            if (byte_end) begin
                case (phase)
                    PH_CMD: begin
                        if (match) begin
                            phase    <= PH_DATA;
                            rd_mode  <= cmd.rd;
                            cur_addr <= cmd.rd ? step_addr(cmd.reg_addr) : cmd.reg_addr;
                        end else begin
                            phase <= PH_SKIP;
                        end
                    end
                    PH_DATA: cur_addr <= step_addr(cur_addr);
                    default: ;
                endcase
            end
            if (sck_fall && (phase == PH_DATA) && rd_mode) begin
                out_bit <= tx_sh[BYTE_W-1];
                tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
            end
            if (ld_en)
                tx_sh <= rd_byte;
        end
    end

    assign miso    = out_bit;
    assign miso_oe = cs_act && (phase == PH_DATA) && rd_mode;

endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
    import spi_regif_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  addr_t                         wr_addr,
    input  byte_t                         wr_data,
    input  addr_t                         rd_addr,
    input  logic                          snap_en,
    input  logic [NUM_CH-1:0][DATA_W-1:0] ch_live,
    input  byte_t                         mod_live,
    output byte_t                         rd_byte,
    output cfg_t                          cfg
);

    logic [DATA_W-1:0] snap_q [NUM_CH];
    logic [DATA_W-1:0] snap_v [NUM_CH];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst)
                snap_q[c] <= '0;
            else if (snap_en)
                snap_q[c] <= ch_live[c];
        end
        // a capture and the load of address 0x00 may share a cycle
        assign snap_v[c] = snap_en ? ch_live[c] : snap_q[c];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_PHASE: cfg.phase <= wr_data;
                A_GAIN:  cfg.gain  <= wr_data;
                A_STAT:  cfg.stat  <= wr_data & MASK_STAT;
                A_CTL1:  cfg.ctl1  <= wr_data & MASK_CTL1;
                A_CTL2:  cfg.ctl2  <= wr_data;
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_byte = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            for (int b = 0; b < BYTES_PER_CH; b++) begin
                if (rd_addr == addr_t'(c * BYTES_PER_CH + b))
                    rd_byte = snap_v[c][DATA_W-1-BYTE_W*b -: BYTE_W];
            end
        end
        case (rd_addr)
            A_MODOUT: rd_byte = mod_live;
            A_PHASE:  rd_byte = cfg.phase;
            A_GAIN:   rd_byte = cfg.gain;
            A_STAT:   rd_byte = cfg.stat & MASK_STAT;
            A_CTL1:   rd_byte = cfg.ctl1 & MASK_CTL1;
            A_CTL2:   rd_byte = cfg.ctl2;
            default:  ;
        endcase
    end

endmodule

// File: rtl/conv_spi_regif.sv
module conv_spi_regif
    import spi_regif_pkg::*;
#(
    parameter logic [DEVA_W-1:0] DEV_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sck,
    input  logic              spi_csn,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    input  logic [DATA_W-1:0] ch0_sample,
    input  logic [DATA_W-1:0] ch1_sample,
    input  logic [BYTE_W-1:0] mod_bits,
    output logic [BYTE_W-1:0] cfg_phase,
    output logic [BYTE_W-1:0] cfg_gain,
    output logic [BYTE_W-1:0] cfg_status,
    output logic [BYTE_W-1:0] cfg_ctrl1,
    output logic [BYTE_W-1:0] cfg_ctrl2
);

    logic   cs_act;
    logic   sck_rise;
    logic   sck_fall;
    logic   mosi_s;
    byte_t  rd_byte;
    addr_t  rd_addr;
    logic   ld_en;
    logic   snap_en;
    logic   wr_en;
    addr_t  wr_addr;
    byte_t  wr_data;
    addr_t  cur_addr;
    phase_e phase;
    cfg_t   cfg_q;
    logic [NUM_CH-1:0][DATA_W-1:0] ch_live;

    assign ch_live = {ch1_sample, ch0_sample};

    spi_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst      (rst),
        .spi_sck  (spi_sck),
        .spi_csn  (spi_csn),
        .spi_mosi (spi_mosi),
        .cs_act   (cs_act),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .mosi_s   (mosi_s)
    );

    spi_frame_ctl #(.DEV_ADDR(DEV_ADDR)) ctl_i (
        .clk      (clk),
        .rst      (rst),
        .cs_act   (cs_act),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .mosi_s   (mosi_s),
        .rd_byte  (rd_byte),
        .rd_addr  (rd_addr),
        .ld_en    (ld_en),
        .snap_en  (snap_en),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .cur_addr (cur_addr),
        .phase    (phase),
        .miso     (spi_miso),
        .miso_oe  (spi_miso_oe)
    );

    spi_reg_bank bank_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .snap_en  (snap_en),
        .ch_live  (ch_live),
        .mod_live (mod_bits),
        .rd_byte  (rd_byte),
        .cfg      (cfg_q)
    );

    assign cfg_phase  = cfg_q.phase;
    assign cfg_gain   = cfg_q.gain;
    assign cfg_status = cfg_q.stat;
    assign cfg_ctrl1  = cfg_q.ctl1;
    assign cfg_ctrl2  = cfg_q.ctl2;

endmodule

// File: rtl/conv_spi_regif_chk.sv
module conv_spi_regif_chk
    import spi_regif_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   spi_csn,
    input logic   spi_miso_oe,
    input logic   wr_en,
    input addr_t  wr_addr,
    input logic   ld_en,
    input addr_t  rd_addr,
    input addr_t  cur_addr,
    input byte_t  rd_byte,
    input phase_e phase,
    input cfg_t   cfg
);

    // R4: a select held high for several cycles keeps the pad released
    p_quiet_idle_r4: assert property (@(posedge clk) disable iff (rst)
        (spi_csn && $past(spi_csn) && $past(spi_csn, 2) && $past(spi_csn, 3)) |-> !spi_miso_oe);

    // R2: after a foreign device address nothing is driven or written
    p_foreign_silent_r2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SKIP) |-> (!spi_miso_oe && !wr_en));

    // R7: data sent to sample/modulator addresses leaves configuration alone
    p_ro_write_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr <= A_MODOUT)) |=> $stable(cfg));

    // R5: configuration only moves on a completed write byte
    p_cfg_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cfg));

    // R6: sample group loops back to 0x00
    p_data_loop_r6: assert property (@(posedge clk) disable iff (rst)
        (ld_en && (rd_addr == A_DATA_LAST)) |=> (cur_addr == '0));

    // R6: control group loops back to the modulator byte
    p_ctl_loop_r6: assert property (@(posedge clk) disable iff (rst)
        (ld_en && (rd_addr == A_CTL2)) |=> (cur_addr == A_MODOUT));

    // R8: unimplemented status bits never appear on the read path
    p_unimpl_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == A_STAT) |-> (rd_byte[1:0] == 2'b00));

endmodule

bind conv_spi_regif conv_spi_regif_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .spi_csn     (spi_csn),
    .spi_miso_oe (spi_miso_oe),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .ld_en       (ld_en),
    .rd_addr     (rd_addr),
    .cur_addr    (cur_addr),
    .rd_byte     (rd_byte),
    .phase       (phase),
    .cfg         (cfg_q)
);

// File: tb/conv_spi_regif_tb_top.sv
module conv_spi_regif_tb_top;

    localparam int H = 12;   // system clocks per serial half period

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        spi_sck = 1'b0;
    logic        spi_csn = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic        spi_miso_oe;
    logic [23:0] ch0_sample = 24'h123456;
    logic [23:0] ch1_sample = 24'hABCDEF;
    logic [7:0]  mod_bits = 8'h96;
    logic [7:0]  cfg_phase, cfg_gain, cfg_status, cfg_ctrl1, cfg_ctrl2;

    always #4 clk = ~clk;

    conv_spi_regif dut_i (
        .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_csn(spi_csn),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .ch0_sample(ch0_sample), .ch1_sample(ch1_sample), .mod_bits(mod_bits),
        .cfg_phase(cfg_phase), .cfg_gain(cfg_gain), .cfg_status(cfg_status),
        .cfg_ctrl1(cfg_ctrl1), .cfg_ctrl2(cfg_ctrl2)
    );

    int n_run = 0;
    int n_fail = 0;
    logic [7:0] m_reg [5];
    logic [7:0] m_mask [5] = '{8'hFF, 8'hFF, 8'hFC, 8'h3F, 8'hFF};
    logic [7:0] exp_q [$];
    string      tag_q [$];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ---- reference model -------------------------------------------------
    function automatic logic [7:0] mdl_rd(input int a);
        logic [23:0] w;
        if (a < 6) begin
            w = (a < 3) ? ch0_sample : ch1_sample;
            return w[23 - 8*(a % 3) -: 8];
        end
        if (a == 6) return mod_bits;
        if (a <= 11) return m_reg[a-7] & m_mask[a-7];
        return 8'h00;
    endfunction

    function automatic int mdl_next(input int a);
        if (a == 5) return 0;
        if (a == 11) return 6;
        if (a > 11) return a;
        return a + 1;
    endfunction

    // driver side: push expected bytes
    task automatic push_reads(input int a, input int n, input string tag);
        int p = a;
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(mdl_rd(p));
            tag_q.push_back(tag);
            p = mdl_next(p);
        end
    endtask

    // monitor side: pop and compare
    task automatic sb_pop(input logic [7:0] act);
        if (exp_q.size() == 0) begin
            chk("SB", {24'h0, act}, 32'hFFFF_FFFF);
        end else begin
            logic [7:0] e = exp_q.pop_front();
            string t = tag_q.pop_front();
            chk(t, {24'h0, act}, {24'h0, e});
        end
    endtask

    task automatic chk_cfg(input string req);
        chk(req, {cfg_phase, cfg_gain, cfg_status, cfg_ctrl1},
                 {m_reg[0], m_reg[1], m_reg[2], m_reg[3]});
        chk(req, {24'h0, cfg_ctrl2}, {24'h0, m_reg[4]});
    endtask

    // ---- serial primitives -----------------------------------------------
    task automatic spi_open(input bit idle_hi);
        spi_sck = idle_hi;
        tick(4);
        spi_csn = 1'b0;
        tick(H);
    endtask

    task automatic spi_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx,
                            output bit oe_any, output bit oe_all);
        rx = '0; oe_any = 1'b0; oe_all = 1'b1;
        for (int i = 7; i > 7 - nb; i--) begin
            spi_sck  = 1'b0;
            spi_mosi = tx[i];
            tick(H);
            rx[i]  = spi_miso;
            oe_any = oe_any | spi_miso_oe;
            oe_all = oe_all & spi_miso_oe;
            spi_sck = 1'b1;
            tick(H);
        end
    endtask

    task automatic spi_close(input bit idle_hi);
        tick(H);
        if (!idle_hi) spi_sck = 1'b0;
        tick(H);
        spi_csn = 1'b1;
        tick(8);
    endtask

    task automatic do_write(input bit idle_hi, input logic [1:0] dev, input int a,
                            input logic [7:0] d [8], input int n);
        logic [7:0] rx; bit any, all;
        spi_open(idle_hi);
        spi_bits({dev, 5'(a), 1'b0}, 8, rx, any, all);
        for (int i = 0; i < n; i++) spi_bits(d[i], 8, rx, any, all);
        spi_close(idle_hi);
    endtask

    task automatic mdl_write(input int a, input logic [7:0] d [8], input int n);
        int p = a;
        for (int i = 0; i < n; i++) begin
            if (p >= 7 && p <= 11) m_reg[p-7] = d[i] & m_mask[p-7];
            p = mdl_next(p);
        end
    endtask

    task automatic do_read(input bit idle_hi, input int a, input int n);
        logic [7:0] rx; bit any, all;
        spi_open(idle_hi);
        spi_bits({2'b00, 5'(a), 1'b1}, 8, rx, any, all);
        chk("R4 oe during control byte", {31'h0, any}, 32'h0);
        for (int i = 0; i < n; i++) begin
            spi_bits(8'h00, 8, rx, any, all);
            chk("R4 oe during read data", {31'h0, all}, 32'h1);
            sb_pop(rx);
        end
        spi_close(idle_hi);
        chk("R4 oe after select high", {31'h0, spi_miso_oe}, 32'h0);
    endtask

    // ---- watchdog --------------------------------------------------------
    initial begin
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // ---- stimulus --------------------------------------------------------
    initial begin
        logic [7:0] rx; bit any, all;
        for (int i = 0; i < 5; i++) m_reg[i] = 8'h00;
        tick(5);
        rst = 1'b0;
        tick(4);

        // R5 reset state
        chk_cfg("R5 reset");
        chk("R4 reset oe", {31'h0, spi_miso_oe}, 32'h0);

        // R1 R3: single write, clock idling low; read back with clock idling high
        do_write(1'b0, 2'b00, 7, '{8'hA5, 0, 0, 0, 0, 0, 0, 0}, 1);
        mdl_write(7, '{8'hA5, 0, 0, 0, 0, 0, 0, 0}, 1);
        chk_cfg("R1 R3 write idle low");
        push_reads(7, 1, "R3 read idle high");
        do_read(1'b1, 7, 1);

        // R7: streamed write loops through control group, 0x06 discarded
        do_write(1'b1, 2'b00, 7, '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 0}, 7);
        mdl_write(7, '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 0}, 7);
        chk_cfg("R7 streamed write with loop");

        // R8: unimplemented bits
        do_write(1'b0, 2'b00, 9, '{8'hFF, 8'hFF, 0, 0, 0, 0, 0, 0}, 2);
        mdl_write(9, '{8'hFF, 8'hFF, 0, 0, 0, 0, 0, 0}, 2);
        chk("R8 status stored", {24'h0, cfg_status}, 32'hFC);
        chk("R8 ctrl1 stored", {24'h0, cfg_ctrl1}, 32'h3F);
        push_reads(9, 2, "R8 readback");
        do_read(1'b0, 9, 2);

        // R5 R6: sample group loop, clock idling low
        push_reads(0, 8, "R6 sample loop");
        do_read(1'b0, 0, 8);

        // R6: control group loop from 0x0A, clock idling high
        push_reads(10, 4, "R6 control loop");
        do_read(1'b1, 10, 4);

        // R7: writes into sample range ignored
        do_write(1'b0, 2'b00, 2, '{8'hDE, 8'hAD, 8'hBE, 8'hEF, 0, 0, 0, 0}, 4);
        chk_cfg("R7 read-only write");
        push_reads(0, 6, "R7 samples intact");
        do_read(1'b0, 0, 6);

        // R2: foreign device address
        do_write(1'b0, 2'b01, 7, '{8'h99, 8'h98, 0, 0, 0, 0, 0, 0}, 2);
        chk_cfg("R2 foreign write");
        spi_open(1'b1);
        spi_bits({2'b10, 5'd7, 1'b1}, 8, rx, any, all);
        spi_bits(8'h00, 8, rx, any, all);
        chk("R2 foreign read oe", {31'h0, any}, 32'h0);
        spi_bits(8'h00, 8, rx, any, all);
        chk("R2 foreign read oe", {31'h0, any}, 32'h0);
        spi_close(1'b1);

        // R10: abort mid-byte
        spi_open(1'b0);
        spi_bits({2'b00, 5'd7, 1'b0}, 8, rx, any, all);
        spi_bits(8'hC3, 4, rx, any, all);
        spi_close(1'b0);
        chk_cfg("R10 partial byte discarded");
        spi_open(1'b0);
        spi_bits(8'hFF, 3, rx, any, all);
        spi_close(1'b0);
        do_write(1'b0, 2'b00, 7, '{8'h42, 0, 0, 0, 0, 0, 0, 0}, 1);
        mdl_write(7, '{8'h42, 0, 0, 0, 0, 0, 0, 0}, 1);
        chk_cfg("R10 fresh transfer after abort");

        // R9: out-of-range addresses
        push_reads(16, 3, "R9 out-of-range read");
        do_read(1'b1, 16, 3);
        do_write(1'b1, 2'b00, 31, '{8'hAA, 8'hBB, 0, 0, 0, 0, 0, 0}, 2);
        chk_cfg("R9 out-of-range write");

        // R11: capture coherence across a mid-loop input change
        push_reads(0, 6, "R11 old pass");
        spi_open(1'b0);
        spi_bits({2'b00, 5'd0, 1'b1}, 8, rx, any, all);
        spi_bits(8'h00, 8, rx, any, all);
        sb_pop(rx);
        ch0_sample = 24'h0F1E2D;
        ch1_sample = 24'h3C4B5A;
        for (int i = 1; i < 6; i++) begin
            spi_bits(8'h00, 8, rx, any, all);
            sb_pop(rx);
        end
        push_reads(0, 3, "R11 new pass after wrap");
        for (int i = 0; i < 3; i++) begin
            spi_bits(8'h00, 8, rx, any, all);
            sb_pop(rx);
        end
        spi_close(1'b0);

        chk("SB queue drained", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule